// File: doc/BRIEF.md
# Serial Uplink Command Block Decoder

This block sits behind an uplink receiver. It takes a serial command bit stream, sampled on the rising edge of the receiver's bit clock, along with a carrier-lock indication. While lock is present, it compares the most recent 32 received bits in parallel against an acquisition run followed by a start word. After that pattern is found, it cuts the stream into back-to-back 64-bit code blocks.

Each block carries 56 information bits, 7 check bits of a shortened-cycle (63,56) BCH code and one filler bit. The block checks each code block in a single combinational step. It corrects any single-bit error and flags any other non-zero syndrome. It then presents the 56 information bits to a downstream buffer with a one-cycle valid strobe and two status flags. A tail code block ends decoding and sends the block back to hunting. Losing lock stops everything at once.

Top module: `uplink_cmd_decoder`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, mode_o reads 0 (inactive), and blk_valid_o, blk_err_o and blk_fix_o read 0. The mode encoding is 0 = inactive, 1 = search, 2 = decode.
- R2: A rising clock edge that samples lock_i low puts mode_o at 0, whatever the mode was. Bits sampled while inactive change nothing: no block is delivered, and a start pattern sent without lock does not start decoding.
- R3: In inactive mode, an edge that samples lock_i high moves mode_o to 1 (search). The bit sampled at that edge is not part of any pattern.
- R4: In search mode, mode_o becomes 2 at the edge that samples the last bit of the 32-bit pattern, sent MSB first. The pattern is 16'h5555 followed by 16'hEB90. Any other 32-bit history, including a wrong acquisition half or a one-bit change in the start word, leaves the mode at 1.
- R5: In decode mode, every 64 sampled bits form one code block, sent MSB first. The bit count restarts at zero on each entry to decode. blk_valid_o is high for exactly the one cycle after the edge that samples bit 64, and blocks follow one another with no gap.
- R6: Block bits 63..8 are the information bits, with the first received bit as the MSB. Bits 7..1 are the check bits, equal to info(x)·x^7 mod (x^7+x^6+x^2+1). Bit 0 is filler and is ignored. A clean block delivers its information bits with blk_err_o = 0 and blk_fix_o = 0.
- R7: A single inverted bit anywhere in block bits 63..1 is corrected. The delivered information is the original, with blk_fix_o = 1 and blk_err_o = 0.
- R8: A non-zero syndrome that matches no single-bit position, such as two inverted bits, gives blk_err_o = 1 and blk_fix_o = 0. The information bits are delivered as received.
- R9: A code block equal to 64'hC5C5_C5C5_C5C5_C579 is not delivered (blk_valid_o stays 0), and mode_o returns to 1 at the edge that samples its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Uplink bit clock, bits sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Carrier lock from the receiver |
| bit_i | input | 1 | Serial uplink data bit |
| mode_o | output | 2 | Current mode: 0 inactive, 1 search, 2 decode |
| blk_valid_o | output | 1 | One-cycle strobe: a decoded block is presented |
| blk_info_o | output | 56 | Information bits of the last delivered block |
| blk_err_o | output | 1 | Last delivered block had an uncorrectable syndrome |
| blk_fix_o | output | 1 | Last delivered block had one bit corrected |

## Verification
Every result is registered once at the edge that samples the deciding bit. Mode changes, the valid strobe and the block status are therefore all due one edge after that bit, with no added latency from correction. The bench drives each bit at the falling edge and samples 1 ns after the following rising edge. It checks mode and block outputs right after the deciding bit, and checks the bit before it to confirm nothing appeared early.

// File: rtl/ucd_pkg.sv
`timescale 1ns/1ps
package ucd_pkg;
  typedef enum logic [1:0] {
    ST_INACTIVE = 2'd0,
    ST_SEARCH   = 2'd1,
    ST_DECODE   = 2'd2
  } ucd_state_e;
endpackage

// File: rtl/ucd_start_detect.sv
`timescale 1ns/1ps
module ucd_start_detect #(
  parameter int unsigned         WIN_W   = 32,
  parameter logic [WIN_W-1:0]    PATTERN = 32'h5555_EB90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_i,
  output logic hit_o
);
  logic [WIN_W-1:0] win_q, win_d;

  // window only holds bits seen while searching; cleared otherwise
  always_comb begin
    if (shift_en) win_d = {win_q[WIN_W-2:0], bit_i};
    else          win_d = '0;
    hit_o = shift_en && (win_d == PATTERN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/ucd_block_shift.sv
`timescale 1ns/1ps
module ucd_block_shift #(
  parameter int unsigned BLK_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_i,
  output logic             full_o,
  output logic [BLK_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(BLK_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] sreg_q, sreg_d;

  always_comb begin
    word_o = {sreg_q[BLK_W-2:0], bit_i};
    full_o = en && (cnt_q == LAST);
    if (!en)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
    sreg_d = en ? word_o : sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end
endmodule

// File: rtl/ucd_bch_fix.sv
`timescale 1ns/1ps
module ucd_bch_fix #(
  parameter int unsigned       CW_N   = 63,
  parameter int unsigned       INFO_W = 56,
  parameter logic [CW_N-INFO_W:0] GEN = 8'hC5
) (
  input  logic [CW_N-1:0]   cw_i,
  output logic [INFO_W-1:0] info_o,
  output logic              fix_o,
  output logic              err_o
);
  localparam int unsigned CHK_W = CW_N - INFO_W;

  function automatic logic [CHK_W-1:0] remainder(input logic [CW_N-1:0] v);
    logic [CHK_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = CW_N - 1; i >= 0; i--) begin
      fb = r[CHK_W-1] ^ v[i];
      r  = {r[CHK_W-2:0], 1'b0} ^ (fb ? GEN[CHK_W-1:0] : '0);
    end
    return r;
  endfunction

  logic [CHK_W-1:0] syn;
  logic [CW_N-1:0]  hit_vec;
  logic [CW_N-1:0]  fixed;

  assign syn = remainder(cw_i);

  // one parallel comparator per bit position
  for (genvar g = 0; g < CW_N; g++) begin : g_pos
    localparam logic [CHK_W-1:0] SIG = remainder(CW_N'(1) << g);
    assign hit_vec[g] = (syn == SIG);
  end

  always_comb begin
    fixed  = cw_i ^ hit_vec;
    info_o = fixed[CW_N-1:CHK_W];
    fix_o  = |hit_vec;
    err_o  = (syn != '0) && !fix_o;
  end
endmodule

// File: rtl/uplink_cmd_decoder.sv
`timescale 1ns/1ps
module uplink_cmd_decoder #(
  parameter logic [15:0] ACQ_WORD   = 16'h5555,
  parameter logic [15:0] START_WORD = 16'hEB90,
  parameter int unsigned BLK_W      = 64,
  parameter int unsigned INFO_W     = 56,
  parameter logic [BLK_W-1:0] TAIL_WORD = 64'hC5C5_C5C5_C5C5_C579,
  parameter logic [BLK_W-1-INFO_W:0]  GEN_POLY  = 8'hC5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              bit_i,
  output logic [1:0]        mode_o,
  output logic              blk_valid_o,
  output logic [INFO_W-1:0] blk_info_o,
  output logic              blk_err_o,
  output logic              blk_fix_o
);
  import ucd_pkg::*;

  localparam int unsigned CW_N  = BLK_W - 1;
  localparam int unsigned WIN_W = 32;
  localparam logic [WIN_W-1:0] SYNC_PAT = {ACQ_WORD, START_WORD};

  ucd_state_e        state_q, state_d;
  logic              start_hit, blk_full, tail_hit;
  logic [BLK_W-1:0]  blk_word;
  logic [INFO_W-1:0] fix_info;
  logic              fix_flag, err_flag;
  logic              valid_d, err_d, fix_d;
  logic [INFO_W-1:0] info_d;
  logic              srch_en, dec_en;

  assign srch_en = lock_i && (state_q == ST_SEARCH);
  assign dec_en  = lock_i && (state_q == ST_DECODE);

  ucd_start_detect #(.WIN_W(WIN_W), .PATTERN(SYNC_PAT)) u_sync (
    .clk(clk), .rst_n(rst_n), .shift_en(srch_en), .bit_i(bit_i), .hit_o(start_hit)
  );

  ucd_block_shift #(.BLK_W(BLK_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .bit_i(bit_i),
    .full_o(blk_full), .word_o(blk_word)
  );

  ucd_bch_fix #(.CW_N(CW_N), .INFO_W(INFO_W), .GEN(GEN_POLY)) u_bch (
    .cw_i(blk_word[BLK_W-1:1]), .info_o(fix_info), .fix_o(fix_flag), .err_o(err_flag)
  );

  assign tail_hit = blk_full && (blk_word == TAIL_WORD);

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (!lock_i) begin
      state_d = ST_INACTIVE;
    end else begin
      case (state_q)
        ST_INACTIVE: state_d = ST_SEARCH;
        ST_SEARCH:   if (start_hit) state_d = ST_DECODE;
        ST_DECODE:   if (tail_hit)  state_d = ST_SEARCH;
        default:     state_d = ST_INACTIVE;
      endcase
    end
    valid_d = blk_full && !tail_hit;
    info_d  = valid_d ? fix_info : blk_info_o;
    err_d   = valid_d ? err_flag : blk_err_o;
    fix_d   = valid_d ? fix_flag : blk_fix_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_INACTIVE;
      blk_valid_o <= 1'b0;
      blk_info_o  <= '0;
      blk_err_o   <= 1'b0;
      blk_fix_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      blk_valid_o <= valid_d;
      blk_info_o  <= info_d;
      blk_err_o   <= err_d;
      blk_fix_o   <= fix_d;
    end
  end

  assign mode_o = state_q;

  // R2
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (state_q == ST_INACTIVE && !blk_valid_o));
  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INACTIVE && lock_i) |=> (state_q == ST_SEARCH));
  // R4
  no_early_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH && !start_hit) |=> (state_q != ST_DECODE));
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o |=> !blk_valid_o);
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_fix_o |-> !blk_err_o);
  // R9
  tail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hit |=> (!blk_valid_o && state_q == ST_SEARCH));
endmodule

// File: tb/sim_uplink_cmd_decoder.sv
`timescale 1ns/1ps
module sim_uplink_cmd_decoder;
  logic        clk, rst_n, lock_i, bit_i;
  logic [1:0]  mode_o;
  logic        blk_valid_o, blk_err_o, blk_fix_o;
  logic [55:0] blk_info_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [31:0] SYNC = 32'h5555_EB90;
  localparam logic [63:0] TAIL = 64'hC5C5_C5C5_C5C5_C579;

  // {info, flip mask, expected err, expected fix}
  localparam int NV = 7;
  localparam logic [121:0] VEC [NV] = '{
    {56'h12_3456_789A_BCDE, 64'h0,                   1'b0, 1'b0},
    {56'hFF_0000_FFFF_0001, 64'h0,                   1'b0, 1'b0},
    {56'hA5_5A5A_A5A5_0F0F, 64'h8000_0000_0000_0000, 1'b0, 1'b1},
    {56'h00_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0, 1'b1},
    {56'h13_5792_4680_ACE1, 64'h0000_0000_0000_0001, 1'b0, 1'b0},
    {56'hDE_ADBE_EF01_2345, 64'h0000_0000_0000_0006, 1'b1, 1'b0},
    {56'h0F_1E2D_3C4B_5A69, 64'h0000_0100_0000_0000, 1'b0, 1'b1}
  };

  uplink_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .bit_i(bit_i),
    .mode_o(mode_o), .blk_valid_o(blk_valid_o), .blk_info_o(blk_info_o),
    .blk_err_o(blk_err_o), .blk_fix_o(blk_fix_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [6:0] enc_chk(input logic [55:0] info);
    logic [62:0] v;
    v = {info, 7'b0};
    for (int i = 62; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'hC5;
    return v[6:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic sync_up(input string req);
    send_bits({32'h0, SYNC}, 32);
    chk(mode_o == 2'd2, req, {62'h0, mode_o}, 64'd2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] blk;
    rst_n = 1'b0; lock_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(mode_o == 2'd0 && !blk_valid_o && !blk_err_o && !blk_fix_o, "R1",
        {59'h0, mode_o, blk_valid_o, blk_err_o, blk_fix_o}, 64'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(mode_o == 2'd0 && !blk_valid_o, "R1", {62'h0, mode_o}, 64'h0);

    // R2: pattern without lock is ignored
    send_bits({32'h0, SYNC}, 32);
    chk(mode_o == 2'd0, "R2", {62'h0, mode_o}, 64'd0);

    // R3: lock rises
    lock_i = 1'b1;
    send_bit(1'b1);
    chk(mode_o == 2'd1, "R3", {62'h0, mode_o}, 64'd1);

    // R4: wrong acquisition half, then one-bit start error
    send_bits(64'h0000_EB90, 32);
    chk(mode_o == 2'd1, "R4", {62'h0, mode_o}, 64'd1);
    send_bits(64'h5555_EB91, 32);
    chk(mode_o == 2'd1, "R4", {62'h0, mode_o}, 64'd1);
    send_bits({32'h0, SYNC} >> 1, 31);
    chk(mode_o == 2'd1, "R4", {62'h0, mode_o}, 64'd1);
    send_bit(SYNC[0]);
    chk(mode_o == 2'd2, "R4", {62'h0, mode_o}, 64'd2);

    // R5..R8: table of code blocks, back to back
    for (int v = 0; v < NV; v++) begin
      blk = {VEC[v][121:66], enc_chk(VEC[v][121:66]), 1'b0} ^ VEC[v][65:2];
      send_bits(blk >> 1, 63);
      chk(!blk_valid_o, "R5", {63'h0, blk_valid_o}, 64'd0);
      send_bit(blk[0]);
      chk(blk_valid_o, "R5", {63'h0, blk_valid_o}, 64'd1);
      chk(blk_info_o == VEC[v][121:66], VEC[v][0] ? "R7" : (VEC[v][1] ? "R8" : "R6"),
          {8'h0, blk_info_o}, {8'h0, VEC[v][121:66]});
      chk(blk_err_o == VEC[v][1] && blk_fix_o == VEC[v][0],
          VEC[v][1] ? "R8" : (VEC[v][0] ? "R7" : "R6"),
          {62'h0, blk_err_o, blk_fix_o}, {62'h0, VEC[v][1:0]});
    end

    // R9: tail block
    send_bits(TAIL, 64);
    chk(!blk_valid_o && mode_o == 2'd1, "R9", {61'h0, mode_o, blk_valid_o}, 64'd2);

    // R2: lock lost mid-block
    sync_up("R4");
    send_bits(64'hABCDE, 20);
    @(negedge clk); lock_i = 1'b0; bit_i = 1'b1;
    @(posedge clk); #1;
    chk(mode_o == 2'd0, "R2", {62'h0, mode_o}, 64'd0);
    send_bits({32'h0, SYNC}, 32);
    send_bits(64'h1234_5678_9ABC_DEF0, 64);
    chk(mode_o == 2'd0 && !blk_valid_o, "R2", {61'h0, mode_o, blk_valid_o}, 64'd0);

    // R5: count restarts on new entry to decode
    lock_i = 1'b1;
    send_bit(1'b0);
    chk(mode_o == 2'd1, "R3", {62'h0, mode_o}, 64'd1);
    sync_up("R4");
    blk = {56'h77_6655_4433_2211, enc_chk(56'h77_6655_4433_2211), 1'b1};
    send_bits(blk >> 1, 63);
    chk(!blk_valid_o, "R5", {63'h0, blk_valid_o}, 64'd0);
    send_bit(blk[0]);
    chk(blk_valid_o && blk_info_o == 56'h77_6655_4433_2211 && !blk_err_o && !blk_fix_o, "R5",
        {8'h0, blk_info_o}, 64'h0077_6655_4433_2211);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule